// File: doc/BRIEF.md
# Linear Soft-Mute Ramp Controller

This block fades incoming signed audio samples in and out before they reach the sample buffer. It holds a 12-bit gain count. The count moves one step for each input sample period, indicated by a single-cycle word strobe. While the mute request is high the count steps down toward zero gain. While the request is low it steps up toward unity gain. A full sweep in either direction covers 4096 gain levels, so the fade is linear and always has the same length.

The scaled sample is the input multiplied by the count and divided by 4096, with the result truncated toward zero. The top gain level is treated as exact unity. After reset the block starts fully muted. A host that needs audio simply drops the mute request and waits for the unity flag. When the request flips part-way through a fade, the ramp turns around at the level it has reached.

Top module: `soft_mute_ramp`

## Requirements
- R1: While reset is applied and after it is released, the gain count is 0: `full_mute_o` is 1, `unity_o` is 0 and `sample_o` is 0 for any input.
- R2: With `mute_req_i` high, each cycle with `word_stb_i` high lowers the gain count by exactly 1 while it is above 0.
- R3: With `mute_req_i` low, each cycle with `word_stb_i` high raises the gain count by exactly 1 while it is below 4095.
- R4: In cycles with `word_stb_i` low the gain count does not change, whatever `mute_req_i` does.
- R5: The count saturates. A strobe at count 0 with mute high leaves it at 0, and a strobe at count 4095 with mute low leaves it at 4095. It never wraps.
- R6: When `mute_req_i` changes in the middle of a ramp, the next strobe moves the count one step in the new direction from its present value, with no jump.
- R7: For counts 1 to 4094, `sample_o` equals the 24-bit signed `sample_i` times the count divided by 4096, truncated toward zero. It is combinational from `sample_i` and the current count.
- R8: At count 4095 `sample_o` equals `sample_i` exactly. At count 0 `sample_o` is exactly 0.
- R9: `full_mute_o` is 1 exactly when the count is 0. `unity_o` is 1 exactly when the count is 4095. Going from 0 to 4095 takes 4095 strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mute_req_i | input | 1 | 1 = fade toward silence, 0 = fade toward unity |
| word_stb_i | input | 1 | One-cycle pulse once per input sample period |
| sample_i | input | 24 | Signed input sample |
| sample_o | output | 24 | Signed scaled sample |
| full_mute_o | output | 1 | Gain count is 0 |
| unity_o | output | 1 | Gain count is 4095 |

## Verification
The step assertions assume that `word_stb_i` is sampled at the clock edge and lasts one cycle per sample period. They also assume that `mute_req_i` is stable at that edge. The bench drives every input on the falling edge and pulses the strobe for exactly one cycle, so each strobe counts once. The scaling checks assume `sample_i` is known whenever the count is read. The bench therefore holds a defined sample from the start of reset. It reads the count through the datapath by feeding a sample of 4096.

// File: rtl/smr_pkg.sv
package smr_pkg;
  typedef enum logic [1:0] {
    RAMP_HOLD = 2'd0,
    RAMP_DOWN = 2'd1,
    RAMP_UP   = 2'd2
  } ramp_dir_e;
endpackage

// File: rtl/smr_rst_sync.sv
module smr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/smr_ramp_counter.sv
module smr_ramp_counter
  import smr_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mute_req_i,
  input  logic             word_stb_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CntMax = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  ramp_dir_e        dir;
  logic             cnt_en;

  always_comb begin
    dir = RAMP_HOLD;
    if (word_stb_i) begin
      if (mute_req_i && (cnt_q != '0))      dir = RAMP_DOWN;
      else if (!mute_req_i && (cnt_q != CntMax)) dir = RAMP_UP;
    end
  end

  assign cnt_en = (dir != RAMP_HOLD);

  always_comb begin
    cnt_d = cnt_q;
    unique case (dir)
      RAMP_DOWN: cnt_d = cnt_q - 1'b1;
      RAMP_UP:   cnt_d = cnt_q + 1'b1;
      default:   cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R2: a strobe while muting moves the count one step down
  p_step_down_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_stb_i && mute_req_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R3: a strobe while unmuting moves the count one step up
  p_step_up_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_stb_i && !mute_req_i && cnt_q != CntMax) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R4: no strobe, no movement
  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !word_stb_i |=> $stable(cnt_q));

  // R5: saturation at both ends
  p_sat_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mute_req_i && cnt_q == '0) |=> (cnt_q == '0));
  p_sat_high_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mute_req_i && cnt_q == CntMax) |=> (cnt_q == CntMax));
endmodule

// File: rtl/smr_gain_mult.sv
module smr_gain_mult #(
  parameter int DATA_W = 24,
  parameter int CNT_W  = 12
) (
  input  logic signed [DATA_W-1:0] sample_i,
  input  logic        [CNT_W-1:0]  gain_i,
  output logic signed [DATA_W-1:0] sample_o
);
  localparam int PROD_W = DATA_W + CNT_W + 1;
  localparam logic [CNT_W-1:0] GainMax = {CNT_W{1'b1}};
  localparam logic signed [PROD_W-1:0] NegBias = PROD_W'((1 << CNT_W) - 1);

  logic signed [PROD_W-1:0] prod, biased, shifted;

  always_comb begin
    prod    = PROD_W'(sample_i) * $signed({{(PROD_W-CNT_W){1'b0}}, gain_i});
    biased  = prod[PROD_W-1] ? (prod + NegBias) : prod;
    shifted = biased >>> CNT_W;
    if (gain_i == GainMax) sample_o = sample_i;
    else                   sample_o = shifted[DATA_W-1:0];
  end

  // R8: exact unity and exact silence at the ends of the ramp
  always_comb begin
    if (!$isunknown({sample_i, gain_i})) begin
      if (gain_i == '0)
        p_zero_out_r8: assert (sample_o == '0);
      if (gain_i == GainMax)
        p_unity_out_r8: assert (sample_o == sample_i);
      // R7: scaling never flips sign
      if (sample_i >= 0)
        p_sign_keep_r7: assert (sample_o >= 0);
    end
  end
endmodule

// File: rtl/soft_mute_ramp.sv
module soft_mute_ramp #(
  parameter int DATA_W = 24,
  parameter int CNT_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mute_req_i,
  input  logic              word_stb_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic [DATA_W-1:0] sample_o,
  output logic              full_mute_o,
  output logic              unity_o
);
  localparam logic [CNT_W-1:0] CntMax = {CNT_W{1'b1}};

  logic             rst_n_sync;
  logic [CNT_W-1:0] gain_cnt;

  smr_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_sync)
  );

  smr_ramp_counter #(.CNT_W(CNT_W)) u_ramp (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_sync),
    .mute_req_i (mute_req_i),
    .word_stb_i (word_stb_i),
    .cnt_o      (gain_cnt)
  );

  smr_gain_mult #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_mult (
    .sample_i (sample_i),
    .gain_i   (gain_cnt),
    .sample_o (sample_o)
  );

  assign full_mute_o = (gain_cnt == '0);
  assign unity_o     = (gain_cnt == CntMax);

  // R9: the two end flags are never up together
  p_flags_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    $onehot0({full_mute_o, unity_o}));

  // R6: leaving full mute only happens on an unmuting strobe
  p_leave_mute_r6: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    $fell(full_mute_o) |-> $past(word_stb_i && !mute_req_i));
endmodule

// File: tb/soft_mute_ramp_tb.sv
module soft_mute_ramp_tb;
  localparam int DW = 24;
  localparam int MAXC = 4095;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          mute;
  logic          stb;
  logic [DW-1:0] smp;
  logic [DW-1:0] out;
  logic          fm, un;

  int n_chk = 0;
  int n_bad = 0;
  int model_cnt = 0;

  always #2 clk = ~clk;

  soft_mute_ramp u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mute_req_i(mute), .word_stb_i(stb),
    .sample_i(smp), .sample_o(out), .full_mute_o(fm), .unity_o(un)
  );

  function automatic int expect_out(int s, int c);
    longint p;
    if (c == MAXC) return s;
    p = longint'(s) * longint'(c);
    return int'(p / 4096);
  endfunction

  task automatic check(string tag, longint got, longint exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic check_count(string tag);
    smp = 24'd4096;
    #0.5;
    check(tag, longint'($signed(out)), longint'(expect_out(4096, model_cnt)));
    check({tag, " full_mute"}, fm, model_cnt == 0);
    check({tag, " unity"}, un, model_cnt == MAXC);
  endtask

  task automatic strobe(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); stb = 1'b1;
      @(negedge clk); stb = 1'b0;
      if (mute && model_cnt > 0) model_cnt--;
      else if (!mute && model_cnt < MAXC) model_cnt++;
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    check_count("R1 during reset");
    smp = 24'h7FFFFF; #0.5;
    check("R1 out zero in reset", out, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_count("R1 after release");
  endtask

  task automatic t_ramp_up;
    mute = 1'b0;
    strobe(1);   check_count("R3 first step");
    strobe(99);  check_count("R3 step 100");
    strobe(3995); check_count("R9 reached unity after 4095");
    smp = 24'h812345; #0.5;
    check("R8 unity passthrough", out, 24'h812345);
  endtask

  task automatic t_sat_up;
    strobe(3);
    check_count("R5 saturate at 4095");
  endtask

  task automatic t_hold;
    mute = 1'b1;
    repeat (10) @(negedge clk);
    mute = 1'b0;
    repeat (5) @(negedge clk);
    mute = 1'b1;
    repeat (5) @(negedge clk);
    check_count("R4 no strobe no change");
  endtask

  task automatic t_reverse;
    mute = 1'b1;
    strobe(10); check_count("R2 ten steps down");
    mute = 1'b0;
    strobe(1);  check_count("R6 reverse one step");
    strobe(2);  check_count("R6 continue up");
  endtask

  task automatic t_scale;
    mute = 1'b1;
    strobe(model_cnt - 2048);
    check_count("R2 down to 2048");
    smp = 24'h800000; #0.5;
    check("R7 min x half", $signed(out), -4194304);
    smp = 24'h7FFFFF; #0.5;
    check("R7 max x half trunc", $signed(out), 4194303);
    smp = 24'hFFFFFF; #0.5;
    check("R7 -1 toward zero", $signed(out), 0);
    strobe(2048 - 1000);
    smp = -24'sd12345; #0.5;
    check("R7 negative at 1000", $signed(out), expect_out(-12345, 1000));
    smp = 24'd987654; #0.5;
    check("R7 positive at 1000", $signed(out), expect_out(987654, 1000));
  endtask

  task automatic t_ramp_down;
    mute = 1'b1;
    strobe(model_cnt);
    check_count("R9 reached full mute");
    strobe(2);
    check_count("R5 saturate at 0");
    smp = 24'h800000; #0.5;
    check("R8 zero at count 0", out, 0);
  endtask

  initial begin
    rst_n = 1'b0; mute = 1'b1; stb = 1'b0; smp = 24'd4096;
    t_reset();
    t_ramp_up();
    t_sat_up();
    t_hold();
    t_reverse();
    t_scale();
    t_ramp_down();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule